// File: doc/BRIEF.md
# Registered ROM with Programmable Initialize Word

This block is a synthesizable read-only memory of 2048 bytes. The addressed byte is captured into an output pipeline register on each rising clock edge. The block also keeps two configuration words. The first is an initialize word, which an active-low, level-sensitive initialize input forces into the output register at once. The second is an output-enable mode bit. It chooses between an enable that acts on the outputs combinationally and an enable that is sampled by a register on the clock.

Before normal use, a loader fills the memory image through a write port that only works while a program-mode input is high. Image addresses below 0x800 select data words, 0x800 selects the initialize word and 0x801 selects the mode byte. The 8-bit output bus stands in for tri-state pins. A per-bit drive-enable vector shows when each bit would be driven, and the data lines read zero when they are not driven.

Top module: `regrom_top`

## Requirements
- R1: A word address on `rd_addr` sampled at a rising edge with `init_n` high loads that word into the output register, which then holds until the next rising edge whatever the address does in between.
- R2: A load with `prog_mode` and `prog_we` high at a rising edge writes `prog_data` as follows: image address 0x000 to 0x7FF goes to the data word at that address, 0x800 goes to the initialize word, and 0x801 goes to the mode byte. A word written this way reads back on a later access.
- R3: A load is ignored when `prog_mode` is low, and also when the image address is above 0x801. In either case no data word, initialize word or mode bit changes.
- R4: While `rst_n` is low, every data word, the initialize word, the mode byte and the output register are cleared to 0x00. The block therefore starts in asynchronous enable mode with an all-zero initialize word.
- R5: Bit 0 of the mode byte selects the enable mode: 0 is asynchronous and 1 is synchronous. The values 0x00 and 0x01 are the two intended settings.
- R6: In asynchronous mode, `dout_oe` is 0xFF and `dout` equals the output register whenever `en_n` is low. Whenever `en_n` is high, both are 0x00. Either change takes effect without a clock edge.
- R7: In synchronous mode, `en_n` is sampled at each rising edge, and the outputs turn on or off only after the edge that sampled the new level.
- R8: The sampled-enable register is forced to its disabled state during reset and during every edge with `prog_mode` high. In synchronous mode the outputs therefore stay off after programming until an edge samples `en_n` low.
- R9: A low level on `init_n` loads the initialize word into the output register at once, independent of the clock. The word is visible on `dout` only while the outputs are enabled.
- R10: While `init_n` is low across a rising edge, the output register keeps the initialize word rather than the addressed data.
- R11: The initialize word may be any pattern. All zeros make initialize a clear, all ones make it a preset, and a mixed pattern is loaded bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge captures data and the sampled enable |
| rst_n | input | 1 | Active-low power-on clear of the image and registers |
| prog_mode | input | 1 | High allows image loads and holds the sampled enable off |
| prog_we | input | 1 | Load strobe, sampled at the rising edge |
| prog_addr | input | 12 | Image address: data words, initialize word, mode byte |
| prog_data | input | 8 | Byte to load |
| rd_addr | input | 11 | Word address for reads |
| en_n | input | 1 | Active-low output enable |
| init_n | input | 1 | Active-low level-sensitive initialize |
| dout | output | 8 | Output register value while enabled, zero otherwise |
| dout_oe | output | 8 | Per-bit drive flags, all set while enabled |

## Verification
The hardest case to reach from the ports is an initialize pulse that falls and rises again inside one clock period. The register must then show the initialize word until the next edge, and not the addressed data. The second hard case is the start of synchronous mode, where outputs stay off after programming until the first edge that samples the enable low. The stimulus changes inputs one nanosecond after each falling edge and places extra checks a few nanoseconds after those changes. This separates immediate effects from edge-timed ones, while a behavioural model is compared with the outputs at every falling edge.

// File: rtl/regrom_pkg.sv
package regrom_pkg;

    typedef enum logic {
        OE_ASYNC = 1'b0,
        OE_SYNC  = 1'b1
    } oe_mode_e;

    localparam int MODE_BIT = 0;

endpackage

// File: rtl/regrom_store.sv
module regrom_store
    import regrom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              prog_we,
    input  logic [ADDR_W:0]   prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] init_word,
    output logic              sync_mode
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] INIT_OFS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] init_w;
        oe_mode_e          mode;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic              mem_we_d;
    logic [ADDR_W-1:0] mem_wa_d;
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Decode one load: the top image bit splits data words from config words
    always_comb begin
        cfg_d    = cfg_q;
        mem_we_d = 1'b0;
        mem_wa_d = prog_addr[ADDR_W-1:0];
        if (prog_mode && prog_we) begin
            if (!prog_addr[ADDR_W]) begin
                mem_we_d = 1'b1;
            end else if (prog_addr[ADDR_W-1:0] == INIT_OFS) begin
                cfg_d.init_w = prog_data;
            end else if (prog_addr[ADDR_W-1:0] == CTRL_OFS) begin
                cfg_d.mode = oe_mode_e'(prog_data[MODE_BIT]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{init_w: '0, mode: OE_ASYNC};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (mem_we_d) begin
            mem_q[mem_wa_d] <= prog_data;
        end
    end

    assign rd_word   = mem_q[rd_addr];
    assign init_word = cfg_q.init_w;
    assign sync_mode = (cfg_q.mode == OE_SYNC);

endmodule

// File: rtl/regrom_pipe.sv
module regrom_pipe #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_n,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [DATA_W-1:0] init_word,
    output logic [DATA_W-1:0] data_q
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.data = rd_word;
    end

    // Initialize is a level: it loads asynchronously and also wins at the edge
    always_ff @(posedge clk or negedge rst_n or negedge init_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else if (!init_n) begin
            pipe_q.data <= init_word;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign data_q = pipe_q.data;

endmodule

// File: rtl/regrom_oe.sv
module regrom_oe (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_mode,
    input  logic en_n,
    input  logic sync_mode,
    output logic oe_act
);

    typedef struct packed {
        logic off;
    } en_t;

    en_t en_d, en_q;

    always_comb begin
        en_d     = en_q;
        en_d.off = prog_mode ? 1'b1 : en_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '{off: 1'b1};
        end else begin
            en_q <= en_d;
        end
    end

    assign oe_act = sync_mode ? !en_q.off : !en_n;

endmodule

// File: rtl/regrom_top.sv
module regrom_top #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              prog_we,
    input  logic [ADDR_W:0]   prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              en_n,
    input  logic              init_n,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] dout_oe
);

    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] init_word;
    logic [DATA_W-1:0] data_q;
    logic              sync_mode;
    logic              oe_act;

    regrom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_mode (prog_mode),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .rd_addr   (rd_addr),
        .rd_word   (rd_word),
        .init_word (init_word),
        .sync_mode (sync_mode)
    );

    regrom_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_n    (init_n),
        .rd_word   (rd_word),
        .init_word (init_word),
        .data_q    (data_q)
    );

    regrom_oe u_oe (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_mode (prog_mode),
        .en_n      (en_n),
        .sync_mode (sync_mode),
        .oe_act    (oe_act)
    );

    // Per-bit stand-in for tri-state output buffers
    for (genvar b = 0; b < DATA_W; b++) begin : g_obuf
        assign dout[b]    = oe_act & data_q[b];
        assign dout_oe[b] = oe_act;
    end

endmodule

// File: rtl/regrom_chk.sv
module regrom_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_mode,
    input logic              prog_we,
    input logic [ADDR_W:0]   prog_addr,
    input logic              en_n,
    input logic              init_n,
    input logic              sync_mode,
    input logic [DATA_W-1:0] data_q,
    input logic [DATA_W-1:0] init_word,
    input logic [DATA_W-1:0] dout,
    input logic [DATA_W-1:0] dout_oe
);

    localparam int LAST_CFG = (1 << ADDR_W) + 1;

    // R6
    async_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && !en_n) |-> (dout_oe == {DATA_W{1'b1}} && dout == data_q));

    // R6
    async_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && en_n) |-> (dout_oe == '0 && dout == '0));

    // R7
    sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !prog_mode) |=> (!sync_mode || dout_oe == {DATA_W{!$past(en_n)}}));

    // R8
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_mode |=> (!sync_mode || dout_oe == '0));

    // R10
    init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |=> (data_q == $past(init_word)));

    // R9
    init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_n && !prog_mode && !$past(prog_mode)) |-> (data_q == init_word));

    // R3
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode && prog_we && int'(prog_addr) > LAST_CFG)
            |=> ($stable(init_word) && $stable(sync_mode)));

    // R3
    no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_mode |=> ($stable(init_word) && $stable(sync_mode)));

endmodule

bind regrom_top regrom_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_mode (prog_mode),
    .prog_we   (prog_we),
    .prog_addr (prog_addr),
    .en_n      (en_n),
    .init_n    (init_n),
    .sync_mode (sync_mode),
    .data_q    (data_q),
    .init_word (init_word),
    .dout      (dout),
    .dout_oe   (dout_oe)
);

// File: tb/test_regrom_top.sv
module test_regrom_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_mode = 1'b0;
    logic        prog_we = 1'b0;
    logic [11:0] prog_addr = '0;
    logic [7:0]  prog_data = '0;
    logic [10:0] rd_addr = '0;
    logic        en_n = 1'b0;
    logic        init_n = 1'b1;
    logic [7:0]  dout;
    logic [7:0]  dout_oe;

    int    tests = 0;
    int    fails = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_req = "R4";

    // behavioural reference state
    logic [7:0] m_mem [0:2047];
    logic [7:0] m_init;
    logic [7:0] m_ctrl;
    logic [7:0] m_data;
    logic       m_off;

    regrom_top i_regrom_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_mode (prog_mode),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .rd_addr   (rd_addr),
        .en_n      (en_n),
        .init_n    (init_n),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) m_mem[i] = 8'h00;
            m_init = 8'h00;
            m_ctrl = 8'h00;
            m_data = 8'h00;
            m_off  = 1'b1;
        end else begin
            if (!init_n) m_data = m_init;
            else         m_data = m_mem[rd_addr];
            m_off = prog_mode ? 1'b1 : en_n;
            if (prog_mode && prog_we) begin
                if (prog_addr < 12'h800)       m_mem[prog_addr[10:0]] = prog_data;
                else if (prog_addr == 12'h800) m_init = prog_data;
                else if (prog_addr == 12'h801) m_ctrl = prog_data;
            end
        end
    end

    always @(negedge init_n) begin
        if (rst_n) m_data = m_init;
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            logic       act;
            logic [7:0] ed;
            logic [7:0] eo;
            act = m_ctrl[0] ? !m_off : !en_n;
            ed  = act ? m_data : 8'h00;
            eo  = {8{act}};
            tests++;
            if (dout !== ed || dout_oe !== eo) begin
                fails++;
                $display("FAIL %s cycle compare @%0t: dout=%h oe=%h expected dout=%h oe=%h",
                         cur_req, $time, dout, dout_oe, ed, eo);
            end
        end
    end

    task automatic expect_out(string req, logic [7:0] ed, logic [7:0] eo);
        tests++;
        if (dout !== ed || dout_oe !== eo) begin
            fails++;
            $display("FAIL %s @%0t: dout=%h oe=%h expected dout=%h oe=%h",
                     req, $time, dout, dout_oe, ed, eo);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic load(logic [11:0] a, logic [7:0] d, logic pm);
        step();
        prog_mode = pm;
        prog_we   = 1'b1;
        prog_addr = a;
        prog_data = d;
        step();
        prog_we   = 1'b0;
    endtask

    task automatic rd(int a);
        step();
        rd_addr = 11'(a);
        step();
    endtask

    task automatic do_reset();
        step();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R4 reset state, default async mode with en_n low
        do_reset();
        cmp_on = 1'b1;
        expect_out("R4", 8'h00, 8'hFF);
        rd(7);
        expect_out("R4", 8'h00, 8'hFF);

        // R2 image loads
        cur_req = "R2";
        for (int a = 0; a < 64; a++) load(12'(a), pat(a), 1'b1);
        load(12'h400, pat(12'h400), 1'b1);
        load(12'h7FF, pat(12'h7FF), 1'b1);
        load(12'h800, 8'h5A, 1'b1);
        load(12'h801, 8'h00, 1'b1);
        // R3 ignored loads: out of range and outside program mode
        cur_req = "R3";
        load(12'h802, 8'h01, 1'b1);
        load(12'hFFF, 8'h01, 1'b1);
        step();
        prog_mode = 1'b0;
        load(12'h003, 8'hEE, 1'b0);
        load(12'h801, 8'h01, 1'b0);
        rd(3);
        expect_out("R3", pat(3), 8'hFF);
        step();
        en_n = 1'b1;
        #1 expect_out("R3", 8'h00, 8'h00);
        en_n = 1'b0;

        // R1 reads across the map
        cur_req = "R1";
        rd(0);
        expect_out("R1", pat(0), 8'hFF);
        rd(63);
        expect_out("R1", pat(63), 8'hFF);
        rd(12'h400);
        expect_out("R2", pat(12'h400), 8'hFF);
        rd(12'h7FF);
        expect_out("R1", pat(12'h7FF), 8'hFF);
        rd(10);
        rd_addr = 11'd20;
        #5 expect_out("R1", pat(10), 8'hFF);
        step();
        expect_out("R1", pat(20), 8'hFF);

        // R6 async enable acts without a clock
        cur_req = "R6";
        en_n = 1'b1;
        #1 expect_out("R6", 8'h00, 8'h00);
        en_n = 1'b0;
        #1 expect_out("R6", pat(20), 8'hFF);

        // R9 immediate initialize, R10 held across an edge
        cur_req = "R9";
        step();
        init_n = 1'b0;
        #1 expect_out("R9", 8'h5A, 8'hFF);
        cur_req = "R10";
        step();
        expect_out("R10", 8'h5A, 8'hFF);
        init_n = 1'b1;
        step();
        expect_out("R1", pat(20), 8'hFF);

        // R9 pulse inside one period while disabled, visible once enabled
        cur_req = "R9";
        en_n = 1'b1;
        #1 init_n = 1'b0;
        #2 init_n = 1'b1;
        #1 expect_out("R9", 8'h00, 8'h00);
        en_n = 1'b0;
        #1 expect_out("R9", 8'h5A, 8'hFF);
        step();

        // R11 preset and clear patterns
        cur_req = "R11";
        load(12'h800, 8'hFF, 1'b1);
        step();
        prog_mode = 1'b0;
        init_n = 1'b0;
        #1 expect_out("R11", 8'hFF, 8'hFF);
        init_n = 1'b1;
        load(12'h800, 8'h00, 1'b1);
        step();
        prog_mode = 1'b0;
        rd(5);
        init_n = 1'b0;
        #1 expect_out("R11", 8'h00, 8'hFF);
        init_n = 1'b1;

        // R8 sync mode stays off after programming, R5 mode bit
        cur_req = "R8";
        load(12'h801, 8'h01, 1'b1);
        step();
        expect_out("R8", 8'h00, 8'h00);
        prog_mode = 1'b0;
        #1 expect_out("R8", 8'h00, 8'h00);
        rd_addr = 11'd30;
        step();
        expect_out("R5", pat(30), 8'hFF);

        // R7 enable acts only after a sampling edge
        cur_req = "R7";
        en_n = 1'b1;
        #1 expect_out("R7", pat(30), 8'hFF);
        step();
        expect_out("R7", 8'h00, 8'h00);
        en_n = 1'b0;
        #1 expect_out("R7", 8'h00, 8'h00);
        step();
        expect_out("R7", pat(30), 8'hFF);

        // R9 in sync mode: initialize hidden while disabled
        cur_req = "R9";
        en_n = 1'b1;
        step();
        init_n = 1'b0;
        #1 expect_out("R9", 8'h00, 8'h00);
        en_n = 1'b0;
        step();
        expect_out("R10", 8'h00, 8'hFF);
        init_n = 1'b1;
        step();

        // R5 mode byte 0x02 has bit 0 clear: asynchronous again
        cur_req = "R5";
        load(12'h801, 8'h02, 1'b1);
        step();
        prog_mode = 1'b0;
        en_n = 1'b1;
        #1 expect_out("R5", 8'h00, 8'h00);
        en_n = 1'b0;
        #1 expect_out("R5", pat(30), 8'hFF);

        // R1 scattered reads checked by the cycle model
        cur_req = "R1";
        for (int k = 0; k < 200; k++) begin
            step();
            rd_addr = 11'($urandom_range(0, 63));
            en_n    = (k % 7 == 3);
        end
        en_n = 1'b0;

        // R4 clear again erases the image
        cur_req = "R4";
        cmp_on = 1'b0;
        do_reset();
        cmp_on = 1'b1;
        rd(0);
        expect_out("R4", 8'h00, 8'hFF);
        en_n = 1'b1;
        #1 expect_out("R4", 8'h00, 8'h00);
        step();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule